// File: doc/BRIEF.md
# Two-Level Memory-Map Address Decoder

This block turns a 24-bit processor address into active-low chip selects. The four most significant address bits pick one primary region: system ROM, non-volatile static RAM, system RAM, display RAM, keypad, instrument bus interface, CRT controller, or a shared peripheral window. Inside the peripheral window, a second stage decodes three low address bits into individual peripheral strobes. Some of these are ordinary device selects. Others are action strobes that clear a latch or capture one.

A select can assert only during a qualified bus cycle. A qualified cycle is one where the processor address strobe and the external hardware enable from the timing controller are both active. The decoded selects are registered on the first clock edge of a qualified cycle. They are released combinationally as soon as the qualification drops. An access to an unmapped region asserts no select and raises a bus-error flag instead.

Top module: `memmap_decoder`

## Requirements
- R1: Out of reset, and whenever `as_n` or `cs_en_n` is high, every bit of `prim_sel_n` and `sec_sel_n` is high and `bus_err` is low. Releasing the qualification releases all outputs in the same cycle, without waiting for a clock edge.
- R2: From the first rising clock edge of a qualified cycle, address bits [23:20] drive `prim_sel_n`. Values 0x0 and 0x1 pull bit 0 (ROM) low. Value 0x2 pulls bit 1 (NV-SRAM) low. Values 0x4 to 0x7 pull bit 2 (system RAM) low. Values 0x8, 0x9, 0xA, 0xB and 0xC pull bits 3 (display RAM), 4 (keypad), 5 (bus interface), 6 (CRT controller) and 7 (peripheral window) low, respectively.
- R3: Region values 0x3, 0xD, 0xE and 0xF are unmapped. An access to one of them drives `bus_err` high and leaves every select high.
- R4: When region 0xC is selected, address bits [6:4] choose the secondary strobe. Code 0 drives `sec_sel_n` bit 0 (encoder clear). Code 1 drives bit 1 (interrupt clear). Code 2 drives bit 2 (encoder read). Code 3 drives bit 3 (beeper). Code 4 drives bit 4 (acquisition latch). Codes 5 to 7 drive no secondary strobe, but primary bit 7 is still low.
- R5: The action strobes are `sec_sel_n` bits 0, 1 and 4. They assert only on write cycles (`rw` = 0). On a read, these codes assert no secondary strobe.
- R6: An action strobe is low for exactly one cycle, following the first clock edge of the bus cycle. Ordinary selects stay low for as long as the cycle stays qualified.
- R7: At most one bit of `prim_sel_n` is low, and at most one bit of `sec_sel_n` is low. A secondary strobe is low only while primary bit 7 is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 24 | Processor address bus |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| cs_en_n | input | 1 | External hardware chip-select enable, active low |
| prim_sel_n | output | 8 | Primary region selects, active low |
| sec_sel_n | output | 5 | Peripheral-window strobes, active low |
| bus_err | output | 1 | Unmapped-region access flag |

## Verification
The assertions check several properties on every clock edge:
- each select group is one-hot or idle;
- nothing is selected outside a qualified cycle;
- a bus error never coincides with a select;
- a secondary strobe appears only together with the peripheral-window select;
- an action strobe is gone one edge after it appears.

Some behaviours only the bench scenarios can show. These are the exact mapping of every region value and every secondary code. They also include the write-only gating of the action strobes, and the release of the outputs within the same cycle that the strobe is negated.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int ADDR_W  = 24;
  localparam int REG_W   = 4;
  localparam int N_PRIM  = 8;
  localparam int N_SEC   = 5;
  localparam int SEC_LSB = 4;
  localparam int SEC_W   = 3;

  typedef enum logic [2:0] {
    PR_ROM    = 3'd0,
    PR_NVRAM  = 3'd1,
    PR_SYSRAM = 3'd2,
    PR_DSPRAM = 3'd3,
    PR_KEYPAD = 3'd4,
    PR_BUSIF  = 3'd5,
    PR_CRTC   = 3'd6,
    PR_PERIPH = 3'd7
  } prim_e;

  // strobes that act (clear/latch): write only, one-cycle pulse
  localparam logic [N_SEC-1:0] ACTION_MASK = 5'b10011;
endpackage

// File: rtl/memmap_prim_dec.sv
module memmap_prim_dec
  import memmap_pkg::*;
(
  input  logic [REG_W-1:0]  region,
  output logic [N_PRIM-1:0] hit,
  output logic              unmapped
);
  logic [2:0] idx;
  logic       valid;

  always_comb begin
    valid = 1'b1;
    idx   = PR_ROM;
    unique case (region)
      4'h0, 4'h1:             idx = PR_ROM;
      4'h2:                   idx = PR_NVRAM;
      4'h4, 4'h5, 4'h6, 4'h7: idx = PR_SYSRAM;
      4'h8:                   idx = PR_DSPRAM;
      4'h9:                   idx = PR_KEYPAD;
      4'hA:                   idx = PR_BUSIF;
      4'hB:                   idx = PR_CRTC;
      4'hC:                   idx = PR_PERIPH;
      default:                valid = 1'b0;
    endcase
  end

  always_comb begin
    hit = '0;
    if (valid) hit[idx] = 1'b1;
    unmapped = ~valid;
  end
endmodule

// File: rtl/memmap_sec_dec.sv
module memmap_sec_dec
  import memmap_pkg::*;
(
  input  logic [SEC_W-1:0] code,
  input  logic             in_window,
  input  logic             is_write,
  output logic [N_SEC-1:0] hit
);
  for (genvar i = 0; i < N_SEC; i++) begin : g_strobe
    if (ACTION_MASK[i]) begin : g_act
      assign hit[i] = in_window & is_write & (code == SEC_W'(i));
    end else begin : g_dev
      assign hit[i] = in_window & (code == SEC_W'(i));
    end
  end
endmodule

// File: rtl/memmap_qual.sv
module memmap_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  output logic qual_q,
  output logic first_q
);
  logic qual_qq;
  logic qual_q_nx, qual_qq_nx;

  always_comb begin
    qual_q_nx  = qual;
    qual_qq_nx = qual_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q  <= 1'b0;
      qual_qq <= 1'b0;
    end else begin
      qual_q  <= qual_q_nx;
      qual_qq <= qual_qq_nx;
    end
  end

  assign first_q = qual_q & ~qual_qq;
endmodule

// File: rtl/memmap_sel_stage.sv
module memmap_sel_stage #(
  parameter int           W     = 8,
  parameter logic [W-1:0] PULSE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         qual,
  input  logic         qual_q,
  input  logic         first_q,
  input  logic [W-1:0] hit,
  output logic [W-1:0] act
);
  logic [W-1:0] hit_q, hit_nx;
  logic         cap_en;

  always_comb begin
    cap_en = qual | qual_q;
    hit_nx = qual ? hit : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hit_q <= '0;
    else if (cap_en) hit_q <= hit_nx;
  end

  for (genvar i = 0; i < W; i++) begin : g_out
    if (PULSE[i]) begin : g_pulse
      assign act[i] = hit_q[i] & qual & qual_q & first_q;
    end else begin : g_level
      assign act[i] = hit_q[i] & qual & qual_q;
    end
  end

  // R6
  action_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(act & PULSE)) |=> !(|(act & PULSE)));
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              as_n,
  input  logic              rw,
  input  logic              cs_en_n,
  output logic [N_PRIM-1:0] prim_sel_n,
  output logic [N_SEC-1:0]  sec_sel_n,
  output logic              bus_err
);
  logic              qual, qual_q, first_q;
  logic [N_PRIM-1:0] prim_hit, prim_act;
  logic [N_SEC-1:0]  sec_hit, sec_act;
  logic              unmapped, err_act;

  assign qual = ~as_n & ~cs_en_n;

  memmap_qual u_qual (
    .clk(clk), .rst_n(rst_n), .qual(qual), .qual_q(qual_q), .first_q(first_q)
  );

  memmap_prim_dec u_prim (
    .region(addr[ADDR_W-1 -: REG_W]), .hit(prim_hit), .unmapped(unmapped)
  );

  memmap_sec_dec u_sec (
    .code(addr[SEC_LSB +: SEC_W]), .in_window(prim_hit[PR_PERIPH]),
    .is_write(~rw), .hit(sec_hit)
  );

  memmap_sel_stage #(.W(N_PRIM), .PULSE('0)) u_pstage (
    .clk(clk), .rst_n(rst_n), .qual(qual), .qual_q(qual_q), .first_q(first_q),
    .hit(prim_hit), .act(prim_act)
  );

  memmap_sel_stage #(.W(N_SEC), .PULSE(ACTION_MASK)) u_sstage (
    .clk(clk), .rst_n(rst_n), .qual(qual), .qual_q(qual_q), .first_q(first_q),
    .hit(sec_hit), .act(sec_act)
  );

  memmap_sel_stage #(.W(1), .PULSE(1'b0)) u_estage (
    .clk(clk), .rst_n(rst_n), .qual(qual), .qual_q(qual_q), .first_q(first_q),
    .hit(unmapped), .act(err_act)
  );

  assign prim_sel_n = ~prim_act;
  assign sec_sel_n  = ~sec_act;
  assign bus_err    = err_act;

  // R7
  prim_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~prim_sel_n));
  // R7
  sec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sec_sel_n));
  // R7
  sec_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&sec_sel_n) |-> !prim_sel_n[PR_PERIPH]);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (as_n || cs_en_n) |-> (&prim_sel_n && &sec_sel_n && !bus_err));
  // R3
  err_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (&prim_sel_n && &sec_sel_n));
endmodule

// File: tb/memmap_decoder_tb.sv
module memmap_decoder_tb;
  typedef struct packed {
    logic [7:0] prim_n;
    logic [4:0] sec_n;
    logic       err;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        as_n = 1'b1;
  logic        rw = 1'b1;
  logic        cs_en_n = 1'b1;
  logic [7:0]  prim_sel_n;
  logic [4:0]  sec_sel_n;
  logic        bus_err;

  int n_cmp = 0;
  int n_bad = 0;
  item_t exp_q[$];
  string tag_q[$];
  event  ev_smp;
  bit    done = 1'b0;

  always #4 clk = ~clk;

  memmap_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .as_n(as_n), .rw(rw),
    .cs_en_n(cs_en_n), .prim_sel_n(prim_sel_n), .sec_sel_n(sec_sel_n),
    .bus_err(bus_err)
  );

  function automatic item_t model(logic [23:0] a, logic r, logic q, logic first);
    item_t it;
    int    p;
    logic [2:0] c;
    it = '{prim_n: 8'hFF, sec_n: 5'h1F, err: 1'b0};
    if (!q) return it;
    case (a[23:20])
      4'h0, 4'h1: p = 0;
      4'h2: p = 1;
      4'h4, 4'h5, 4'h6, 4'h7: p = 2;
      4'h8: p = 3;
      4'h9: p = 4;
      4'hA: p = 5;
      4'hB: p = 6;
      4'hC: p = 7;
      default: p = -1;
    endcase
    if (p < 0) begin
      it.err = 1'b1;
      return it;
    end
    it.prim_n[p] = 1'b0;
    if (p == 7) begin
      c = a[6:4];
      if (c == 3'd2 || c == 3'd3) it.sec_n[c] = 1'b0;
      else if ((c == 3'd0 || c == 3'd1 || c == 3'd4) && !r && first)
        it.sec_n[c] = 1'b0;
    end
    return it;
  endfunction

  task automatic push(item_t it, string t);
    exp_q.push_back(it);
    tag_q.push_back(t);
    -> ev_smp;
    #0;
  endtask

  // one bus cycle: two clocked samples plus a sample just after release
  task automatic bus(logic [23:0] a, logic r, logic en_n, string t);
    logic q;
    @(negedge clk);
    addr = a; rw = r; cs_en_n = en_n; as_n = 1'b0;
    q = !en_n;
    @(posedge clk); #2;
    push(model(a, r, q, 1'b1), t);
    @(posedge clk); #2;
    push(model(a, r, q, 1'b0), t);
    @(negedge clk);
    as_n = 1'b1;
    #1;
    push(model(a, r, 1'b0, 1'b0), "R1 release");
    cs_en_n = 1'b1;
  endtask

  initial begin : monitor
    item_t e, g;
    string t;
    forever begin
      @(ev_smp);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      g = '{prim_n: prim_sel_n, sec_n: sec_sel_n, err: bus_err};
      n_cmp++;
      if (g !== e) begin
        n_bad++;
        $display("FAIL %s addr=%h rw=%b: got prim=%b sec=%b err=%b exp prim=%b sec=%b err=%b",
                 t, addr, rw, g.prim_n, g.sec_n, g.err, e.prim_n, e.sec_n, e.err);
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    #1;
    push('{prim_n: 8'hFF, sec_n: 5'h1F, err: 1'b0}, "R1 reset");
    #20 rst_n = 1'b1;
    @(posedge clk); #2;
    push('{prim_n: 8'hFF, sec_n: 5'h1F, err: 1'b0}, "R1 idle after reset");
    // R2 / R3: every region value, read
    for (int r = 0; r < 16; r++)
      bus({r[3:0], 20'h01230}, 1'b1, 1'b0, "R2 R3 region sweep");
    // R3 unmapped write as well
    bus(24'hE00040, 1'b0, 1'b0, "R3 unmapped write");
    // R4 R5 R6: peripheral codes, write then read
    for (int c = 0; c < 8; c++) begin
      bus({4'hC, 13'h0, c[2:0], 4'h5}, 1'b0, 1'b0, "R4 R6 periph write");
      bus({4'hC, 13'h0, c[2:0], 4'h5}, 1'b1, 1'b0, "R4 R5 periph read");
    end
    // R1: external enable inactive blocks every select
    bus(24'h000000, 1'b1, 1'b1, "R1 enable off");
    bus(24'hC00040, 1'b0, 1'b1, "R1 enable off periph");
    bus(24'hF00000, 1'b1, 1'b1, "R1 enable off unmapped");
    // R1: address strobe high with enable active
    @(negedge clk);
    addr = 24'h900000; cs_en_n = 1'b0; as_n = 1'b1;
    @(posedge clk); #2;
    push('{prim_n: 8'hFF, sec_n: 5'h1F, err: 1'b0}, "R1 strobe off");
    cs_en_n = 1'b1;
    // R7: address bits outside the decoded fields do not matter
    bus(24'h5FFF8F, 1'b0, 1'b0, "R7 R2 high bits sysram");
    bus(24'hCFFF3F, 1'b0, 1'b0, "R7 R4 beeper");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule